// File: doc/BRIEF.md
# Code Branch Target Address Unit

This unit forms the next program-counter value for branch, jump and call operations inside a 64KB code segment. Decode logic upstream hands it a request with a mode, the current PC and the immediate field of the instruction. The unit answers with the new PC and a one-cycle done strobe. Four rules share one engine. The relative rule adds a sign-extended 7-bit or 8-bit displacement to the PC. The short-call rule places an 11-bit offset inside a fixed 2KB call window that starts at 1000H. The vector rule reads a pointer from a 16-entry word table at 004AH. The indirect rule takes a 16-bit pointer either straight from the operand or from a data-memory word.

The relative rule, the short-call rule and the register-indirect rule finish in one cycle. The vector rule and the memory-indirect rule drive a word-read request to memory and wait for the read-valid response. They then load the returned word as the PC. While such a fetch is pending, the unit ignores new requests and holds the PC output steady. Condition evaluation, stack pushes for calls and segment switching all belong to the surrounding pipeline.

Top module: `branch_target_unit`

## Requirements
- R1: After reset, pc_out is 0000H, done is 0 and mem_req is 0.
- R2: A request is accepted when req_valid is 1 and no fetch is pending (mem_req is 0). With mode 00 (relative) and disp7 = 0, pc_out becomes cur_pc plus imm[7:0] sign-extended to 16 bits, and done is 1 in the cycle after acceptance.
- R3: With mode 00 and disp7 = 1, only imm[6:0] is used, sign-extended from bit 6. imm[7] and the bits above it have no effect on the target.
- R4: The relative sum is taken modulo 2^16, so FFFFH + 1 gives 0000H and 0000H - 1 gives FFFFH.
- R5: With mode 01 (short call), pc_out becomes 1000H + imm[10:0]. imm[15:11] is ignored and the target always lies in 1000H..17FFH. Done follows in the next cycle.
- R6: With mode 10 (vector), mem_req goes to 1 in the cycle after acceptance, with mem_addr = 004AH + 2 * imm[3:0]. Both stay constant until a cycle in which mem_rvalid is 1.
- R7: In a cycle where mem_req and mem_rvalid are both 1, the unit captures mem_rdata (bit 0 is the lowest-addressed bit of the word). In the following cycle pc_out equals that word, done is 1 and mem_req is 0.
- R8: With mode 11 (indirect) and ind_mem = 0, pc_out becomes imm, and done is 1 in the cycle after acceptance.
- R9: With mode 11 and ind_mem = 1, the unit fetches with mem_addr = imm, and the returned word becomes pc_out as in R7.
- R10: Done is 1 only in the single cycle that follows an accepted one-cycle request or a read-valid response. It is 0 in every other cycle.
- R11: While mem_req is 1, req_valid is ignored. pc_out holds its previous value, done stays 0, and no new request starts after the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Target request strobe |
| mode | input | 2 | 00 relative, 01 short call, 10 vector, 11 indirect |
| disp7 | input | 1 | Relative displacement is 7 bits (1) or 8 bits (0) |
| ind_mem | input | 1 | Indirect pointer is read from memory at imm (1) or is imm itself (0) |
| imm | input | 16 | Immediate field or indirect pointer or pointer address |
| cur_pc | input | 16 | Current program counter |
| mem_req | output | 1 | Word read request, held until response |
| mem_addr | output | 16 | Word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| pc_out | output | 16 | Target program counter |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench targets both wrap points of the relative sum. An adder that kept its carry, or that sign-extended the displacement from the wrong bit, would land outside the segment or a page off. For 7-bit displacements it sets imm[7] against bit 6 to expose decoding of the wrong width. It checks the first and last vector entries and the top of the short-call window, where an unscaled index or an unmasked field would hit the wrong word or escape the window. Under random memory latency it pushes requests in during a fetch, including the response cycle. A design that leaked them would change pc_out, start a second fetch or produce an extra done.

// File: rtl/btu_pkg.sv
package btu_pkg;
   typedef enum logic [1:0] {
      BTU_REL   = 2'b00,
      BTU_SHORT = 2'b01,
      BTU_VECT  = 2'b10,
      BTU_IND   = 2'b11
   } btu_mode_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } btu_state_e;
endpackage

// File: rtl/btu_sext.sv
module btu_sext #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  val_i,
   output logic [OUT_W-1:0] val_o
);
   localparam int PAD_W = OUT_W - IN_W;

   generate
      if (PAD_W > 0) begin : g_pad
         assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
      end else begin : g_nopad
         assign val_o = val_i[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/btu_addr_gen.sv
module btu_addr_gen
   import btu_pkg::*;
#(
   parameter int          PC_W         = 16,
   parameter int          DISP_LONG_W  = 8,
   parameter int          DISP_SHORT_W = 7,
   parameter int          SC_W         = 11,
   parameter logic [15:0] SC_BASE      = 16'h1000,
   parameter int          VEC_IDX_W    = 4,
   parameter int          VEC_STEP_LG2 = 1,
   parameter logic [15:0] VEC_BASE     = 16'h004A
) (
   input  btu_mode_e       mode_i,
   input  logic            disp7_i,
   input  logic            ind_mem_i,
   input  logic [PC_W-1:0] imm_i,
   input  logic [PC_W-1:0] pc_i,
   output logic [PC_W-1:0] direct_tgt_o,
   output logic [PC_W-1:0] fetch_addr_o,
   output logic            needs_fetch_o
);
   localparam int SC_PAD  = PC_W - SC_W;
   localparam int VEC_PAD = PC_W - VEC_IDX_W - VEC_STEP_LG2;

   logic [PC_W-1:0] disp_long, disp_short, disp_sel;
   logic [PC_W-1:0] rel_tgt, short_tgt, vec_addr;

   btu_sext #(.IN_W(DISP_LONG_W), .OUT_W(PC_W)) i_sext_long (
      .val_i (imm_i[DISP_LONG_W-1:0]),
      .val_o (disp_long)
   );

   btu_sext #(.IN_W(DISP_SHORT_W), .OUT_W(PC_W)) i_sext_short (
      .val_i (imm_i[DISP_SHORT_W-1:0]),
      .val_o (disp_short)
   );

   always_comb begin
      disp_sel  = disp7_i ? disp_short : disp_long;
      rel_tgt   = pc_i + disp_sel;
      short_tgt = SC_BASE[PC_W-1:0] + {{SC_PAD{1'b0}}, imm_i[SC_W-1:0]};
      vec_addr  = VEC_BASE[PC_W-1:0]
                + {{VEC_PAD{1'b0}}, imm_i[VEC_IDX_W-1:0], {VEC_STEP_LG2{1'b0}}};
   end

   always_comb begin
      direct_tgt_o  = imm_i;
      fetch_addr_o  = imm_i;
      needs_fetch_o = 1'b0;
      unique case (mode_i)
         BTU_REL:   direct_tgt_o = rel_tgt;
         BTU_SHORT: direct_tgt_o = short_tgt;
         BTU_VECT: begin
            fetch_addr_o  = vec_addr;
            needs_fetch_o = 1'b1;
         end
         BTU_IND:   needs_fetch_o = ind_mem_i;
         default:   needs_fetch_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/btu_fetch_ctl.sv
module btu_fetch_ctl
   import btu_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_direct_i,
   input  logic            start_fetch_i,
   input  logic [PC_W-1:0] direct_tgt_i,
   input  logic [PC_W-1:0] fetch_addr_i,
   input  logic            rvalid_i,
   input  logic [PC_W-1:0] rdata_i,
   output logic            busy_o,
   output logic [PC_W-1:0] addr_o,
   output logic [PC_W-1:0] pc_o,
   output logic            done_o
);
   btu_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_o  <= '0;
         pc_o    <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_direct_i) begin
                  pc_o   <= direct_tgt_i;
                  done_o <= 1'b1;
               end else if (start_fetch_i) begin
                  addr_o  <= fetch_addr_i;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (rvalid_i) begin
                  pc_o    <= rdata_i;
                  done_o  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q == ST_FETCH);
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
   import btu_pkg::*;
#(
   parameter int          PC_W         = 16,
   parameter int          DISP_LONG_W  = 8,
   parameter int          DISP_SHORT_W = 7,
   parameter int          SC_W         = 11,
   parameter logic [15:0] SC_BASE      = 16'h1000,
   parameter int          VEC_IDX_W    = 4,
   parameter int          VEC_STEP_LG2 = 1,
   parameter logic [15:0] VEC_BASE     = 16'h004A
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      mode,
   input  logic            disp7,
   input  logic            ind_mem,
   input  logic [PC_W-1:0] imm,
   input  logic [PC_W-1:0] cur_pc,
   output logic            mem_req,
   output logic [PC_W-1:0] mem_addr,
   input  logic            mem_rvalid,
   input  logic [PC_W-1:0] mem_rdata,
   output logic [PC_W-1:0] pc_out,
   output logic            done
);
   generate
      if (DISP_SHORT_W >= DISP_LONG_W) begin : g_chk_disp
         $error("short displacement must be narrower than long");
      end
      if (DISP_LONG_W >= PC_W) begin : g_chk_long
         $error("long displacement must be narrower than PC");
      end
      if (SC_W >= PC_W || VEC_IDX_W + VEC_STEP_LG2 >= PC_W) begin : g_chk_fld
         $error("call fields must fit inside the PC width");
      end
      if (PC_W > 16) begin : g_chk_pc
         $error("base constants are 16 bits wide");
      end
   endgenerate

   logic            busy;
   logic            accept;
   logic            needs_fetch;
   logic [PC_W-1:0] direct_tgt, fetch_addr;

   assign accept = req_valid && !busy;

   btu_addr_gen #(
      .PC_W(PC_W), .DISP_LONG_W(DISP_LONG_W), .DISP_SHORT_W(DISP_SHORT_W),
      .SC_W(SC_W), .SC_BASE(SC_BASE), .VEC_IDX_W(VEC_IDX_W),
      .VEC_STEP_LG2(VEC_STEP_LG2), .VEC_BASE(VEC_BASE)
   ) i_addr_gen (
      .mode_i        (btu_mode_e'(mode)),
      .disp7_i       (disp7),
      .ind_mem_i     (ind_mem),
      .imm_i         (imm),
      .pc_i          (cur_pc),
      .direct_tgt_o  (direct_tgt),
      .fetch_addr_o  (fetch_addr),
      .needs_fetch_o (needs_fetch)
   );

   btu_fetch_ctl #(.PC_W(PC_W)) i_fetch_ctl (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_direct_i (accept && !needs_fetch),
      .start_fetch_i  (accept && needs_fetch),
      .direct_tgt_i   (direct_tgt),
      .fetch_addr_i   (fetch_addr),
      .rvalid_i       (mem_rvalid),
      .rdata_i        (mem_rdata),
      .busy_o         (busy),
      .addr_o         (mem_addr),
      .pc_o           (pc_out),
      .done_o         (done)
   );

   assign mem_req = busy;
endmodule

// File: rtl/btu_checker.sv
module btu_checker
   import btu_pkg::*;
#(
   parameter int          PC_W      = 16,
   parameter int          SC_W      = 11,
   parameter logic [15:0] SC_BASE   = 16'h1000,
   parameter int          VEC_IDX_W = 4,
   parameter logic [15:0] VEC_BASE  = 16'h004A
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [1:0]      mode,
   input logic            ind_mem,
   input logic [PC_W-1:0] imm,
   input logic            mem_req,
   input logic [PC_W-1:0] mem_addr,
   input logic            mem_rvalid,
   input logic [PC_W-1:0] mem_rdata,
   input logic [PC_W-1:0] pc_out,
   input logic            done
);
   localparam logic [PC_W:0] SC_END = {1'b0, SC_BASE[PC_W-1:0]} + (1 << SC_W);

   logic fetch_mode;
   assign fetch_mode = (mode == BTU_VECT) || (mode == BTU_IND && ind_mem);

   assert_short_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_req && mode == BTU_SHORT) |=>
      (done && {1'b0, pc_out} >= {1'b0, SC_BASE[PC_W-1:0]} && {1'b0, pc_out} < SC_END));

   assert_vec_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_req && mode == BTU_VECT) |=>
      (mem_req && mem_addr == VEC_BASE[PC_W-1:0]
         + {{(PC_W-VEC_IDX_W-1){1'b0}}, $past(imm[VEC_IDX_W-1:0]), 1'b0}));

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   assert_load_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid) |=> (done && !mem_req && pc_out == $past(mem_rdata)));

   assert_reg_ind_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mem_req && mode == BTU_IND && !ind_mem) |=>
      (done && pc_out == $past(imm)));

   assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past((req_valid && !mem_req && !fetch_mode) || (mem_req && mem_rvalid)));

   assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> ($stable(pc_out) && !done));
endmodule

bind branch_target_unit btu_checker #(
   .PC_W(PC_W), .SC_W(SC_W), .SC_BASE(SC_BASE),
   .VEC_IDX_W(VEC_IDX_W), .VEC_BASE(VEC_BASE)
) i_btu_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .mode       (mode),
   .ind_mem    (ind_mem),
   .imm        (imm),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .mem_rdata  (mem_rdata),
   .pc_out     (pc_out),
   .done       (done)
);

// File: tb/test_branch_target_unit.sv
`timescale 1ns/1ps
module test_branch_target_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        disp7 = 1'b0;
   logic        ind_mem = 1'b0;
   logic [15:0] imm = '0;
   logic [15:0] cur_pc = '0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic [15:0] pc_out;
   logic        done;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;
   logic [15:0] last_pc = '0;

   always #2 clk = ~clk;

   branch_target_unit i_branch_target_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
      .disp7(disp7), .ind_mem(ind_mem), .imm(imm), .cur_pc(cur_pc),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .pc_out(pc_out), .done(done)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_direct(input logic [1:0] m, input logic sd,
                                              input logic [15:0] im, input logic [15:0] pc);
      case (m)
         2'b00:   exp_direct = sd ? pc + {{9{im[6]}}, im[6:0]} : pc + {{8{im[7]}}, im[7:0]};
         2'b01:   exp_direct = 16'h1000 + {5'b0, im[10:0]};
         default: exp_direct = im;
      endcase
   endfunction

   function automatic logic [15:0] exp_addr(input logic [1:0] m, input logic [15:0] im);
      exp_addr = (m == 2'b10) ? 16'h004A + {11'b0, im[3:0], 1'b0} : im;
   endfunction

   function automatic logic [15:0] mem_word(input logic [15:0] a);
      mem_word = (a * 16'h9E37) ^ 16'h5A5A;
   endfunction

   task automatic do_req(input logic [1:0] m, input logic sd, input logic im_mem,
                         input logic [15:0] im, input logic [15:0] pc,
                         input string tag, input int lat, input bit poke);
      logic fetch;
      logic [15:0] a, w;
      fetch = (m == 2'b10) || (m == 2'b11 && im_mem);
      @(negedge clk);
      req_valid = 1'b1; mode = m; disp7 = sd; ind_mem = im_mem; imm = im; cur_pc = pc;
      @(negedge clk);
      if (!fetch) begin
         req_valid = 1'b0;
         chk({tag, " done"}, {15'b0, done}, 16'd1);
         chk({tag, " target"}, pc_out, exp_direct(m, sd, im, pc));
         last_pc = exp_direct(m, sd, im, pc);
      end else begin
         a = exp_addr(m, im);
         chk({tag, " R6 mem_req up"}, {15'b0, mem_req}, 16'd1);
         chk({tag, " R6 mem_addr"}, mem_addr, a);
         chk("R10 no done at fetch start", {15'b0, done}, 16'd0);
         if (poke) begin
            req_valid = 1'b1; mode = 2'($urandom_range(0, 3));
            imm = 16'($urandom); cur_pc = 16'($urandom);
         end else req_valid = 1'b0;
         for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R6 mem_req held", {15'b0, mem_req}, 16'd1);
            chk("R6 mem_addr held", mem_addr, a);
            chk("R11 pc held", pc_out, last_pc);
            chk("R11 no done", {15'b0, done}, 16'd0);
         end
         w = mem_word(a);
         mem_rvalid = 1'b1; mem_rdata = w;
         @(negedge clk);
         mem_rvalid = 1'b0; mem_rdata = 16'($urandom); req_valid = 1'b0;
         chk({tag, " R7 done"}, {15'b0, done}, 16'd1);
         chk({tag, " R7 word"}, pc_out, w);
         chk("R7 mem_req drop", {15'b0, mem_req}, 16'd0);
         last_pc = w;
      end
      @(negedge clk);
      chk("R10 done single", {15'b0, done}, 16'd0);
      chk("R11 no leaked fetch", {15'b0, mem_req}, 16'd0);
      chk("R10 pc stays", pc_out, last_pc);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      repeat (3) @(negedge clk);
      chk("R1 pc reset", pc_out, 16'h0000);
      chk("R1 done reset", {15'b0, done}, 16'd0);
      chk("R1 mem_req reset", {15'b0, mem_req}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", {14'b0, mem_req, done}, 16'd0);

      do_req(2'b00, 1'b0, 1'b0, 16'h0001, 16'hFFFF, "R4 wrap up", 0, 1'b0);
      do_req(2'b00, 1'b0, 1'b0, 16'h00FF, 16'h0000, "R4 wrap down", 0, 1'b0);
      do_req(2'b00, 1'b0, 1'b0, 16'h0080, 16'h1234, "R2 min disp", 0, 1'b0);
      do_req(2'b00, 1'b1, 1'b0, 16'hFFBF, 16'h2000, "R3 bit7 set bit6 clr", 0, 1'b0);
      do_req(2'b00, 1'b1, 1'b0, 16'h0040, 16'h0030, "R3 neg 7bit", 0, 1'b0);
      do_req(2'b01, 1'b0, 1'b0, 16'hFFFF, 16'h5555, "R5 top of window", 0, 1'b0);
      do_req(2'b01, 1'b0, 1'b0, 16'hF800, 16'h5555, "R5 base", 0, 1'b0);
      do_req(2'b10, 1'b0, 1'b0, 16'hFFF0, 16'h0000, "R6 vec idx0", 0, 1'b0);
      do_req(2'b10, 1'b0, 1'b0, 16'h000F, 16'h0000, "R6 vec idx15", 3, 1'b1);
      do_req(2'b11, 1'b0, 1'b0, 16'hBEEF, 16'h0000, "R8 reg ind", 0, 1'b0);
      do_req(2'b11, 1'b0, 1'b1, 16'h8642, 16'h0000, "R9 mem ind", 2, 1'b1);

      for (int i = 0; i < 400; i++) begin
         logic [1:0]  m;
         logic        sd, imf;
         logic [15:0] im, pc;
         string       tg;
         m = 2'($urandom_range(0, 3));
         sd = 1'($urandom); imf = 1'($urandom);
         im = 16'($urandom);
         pc = ($urandom_range(0, 7) == 0) ? 16'hFFF0 + 16'($urandom_range(0, 15)) : 16'($urandom);
         case (m)
            2'b00:   tg = sd ? "R3 rand" : "R2 rand";
            2'b01:   tg = "R5 rand";
            2'b10:   tg = "R6 rand";
            default: tg = imf ? "R9 rand" : "R8 rand";
         endcase
         do_req(m, sd, imf, im, pc, tg, $urandom_range(0, 3), 1'($urandom));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule